// File: doc/BRIEF.md
# Prescaled Interval Timer

A three-channel memory-mapped timer. Each channel owns a 16-bit up-counter fed by a power-of-two prescaler. The prescaler takes its ticks either from the block clock or from an external tick strobe. A channel can run freely and wrap at the top of its range. It can also run in interval mode, where it climbs to a programmed limit, returns to zero and latches an event flag. The event flag drives the channel's own interrupt line through an enable mask. Software clears the flag by reading it.

Software reaches the block through a simple synchronous register port with byte addresses. Each register kind has its own group, and inside a group the channels sit at a 4-byte stride. Read data is registered and appears one cycle after the read strobe. A counter-reset strobe inside the counter control word zeroes the counter. Because that strobe and the run/stop bit share one write, software can restart a channel from zero in a single access.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset, every channel's counter control reads 0x1 (stopped, free mode), interval reads 0xFFFF, clock control, counter, status and interrupt enable read 0, and every interrupt output is low.
- R2: In free mode (counter control bit 1 = 0) the counter steps 0xFFFF to 0 and never sets the status flag.
- R3: With clock control bit 0 = 1, the counter advances once every 2^(P+1) source ticks, where P is clock control bits [4:1]. With bit 0 = 0 it advances on every source tick.
- R4: Clock control bit 5 = 0 takes source ticks from every clock cycle. Bit 5 = 1 takes them only in cycles where alt_tick_i is high.
- R5: While counter control bit 0 = 1 the counter holds its value. Clearing the bit resumes counting from the held value.
- R6: Writing counter control with bit 4 = 1 zeroes the counter and the prescaler divider. Bit 4 is never stored and reads as 0. Other bits of the same write take effect as usual, and bits above 1 are ignored.
- R7: In interval mode (counter control bit 1 = 1) the counter counts 0..N, where N is the interval register. The step after N goes to 0 and sets status bit 0.
- R8: A read of the status register returns the flag and clears it. An event in the same cycle as that read leaves the flag set.
- R9: irq_o[n] is high while status bit 0 and interrupt enable bit 0 of channel n are both 1, and it stays high until the flag is cleared.
- R10: Byte offsets are: clock control 0x00, counter control 0x0C, counter (read-only) 0x18, interval 0x24, status (read-only) 0x54, interrupt enable 0x60. Channel n adds 4*n. Other or misaligned addresses read 0, and writes to read-only registers have no effect.
- R11: Read data appears on bus_rdata on the clock edge that samples bus_re and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| alt_tick_i | input | 1 | Alternate source tick strobe |
| irq_o | output | 3 | Per-channel interrupt |

## Verification
The assertions assume a clean bus protocol: one access per cycle, and bus_we and bus_re never high together. They also assume alt_tick_i is a synchronous level. The bench keeps to these rules by driving every access from tasks that raise exactly one strobe for one cycle on the falling edge. Random trials reprogram a channel only while it is stopped, and they restart it with the reset strobe. The count is therefore always at or below the interval limit, which is the only regime where interval-mode arithmetic is defined.

// File: rtl/tmr_pkg.sv
// Shared definitions for the prescaled interval timer: register group
// offsets, channel stride and the packed layout of the clock control word.
package tmr_pkg;
    localparam int unsigned OFS_CLK  = 32'h00;
    localparam int unsigned OFS_CNT  = 32'h0C;
    localparam int unsigned OFS_VAL  = 32'h18;
    localparam int unsigned OFS_IVL  = 32'h24;
    localparam int unsigned OFS_STA  = 32'h54;
    localparam int unsigned OFS_IER  = 32'h60;
    localparam int unsigned CH_STRIDE = 4;
    localparam int EXP_W = 4;

    // Clock control word, bit 5 down to bit 0.
    typedef struct packed {
        logic             src_sel;
        logic [EXP_W-1:0] exp_sel;
        logic             pre_en;
    } clk_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Power-of-two tick divider. Emits adv_o once every 2^(exp_sel+1) source
// ticks when pre_en is set, or on every source tick otherwise.
// Assumes: clr is a synchronous request that zeroes the divider.
module tmr_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_tick,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             adv_o
);
    localparam int DIV_W = 1 << EXP_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             at_lim;

    // Terminal divider value: 2^(exp_sel+1) - 1, saturating for the top exponent.
    always_comb begin
        lim    = ~({DIV_W{1'b1}} << ({1'b0, exp_sel} + (EXP_W+1)'(1)));
        at_lim = (div_q == lim);
        adv_o  = src_tick && (!pre_en || at_lim);
    end

    // Divider register: cleared on request or when bypassed, else counts ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (clr || !pre_en)   div_q <= '0;
        else if (src_tick)         div_q <= at_lim ? '0 : div_q + DIV_W'(1);
    end

    p_div_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0));
    p_adv_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && pre_en) |=> (!adv_o || !pre_en));
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: prescaler, 16-bit up-counter with free or interval
// mode, and the read-clearing event flag.
// Assumes: control inputs are registered; rst_stb and stat_rd are one-cycle strobes.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_cfg_t         clk_cfg,
    input  logic             halt,
    input  logic             ivl_mode,
    input  logic [CNT_W-1:0] interval,
    input  logic             rst_stb,
    input  logic             alt_tick,
    input  logic             stat_rd,
    output logic [CNT_W-1:0] count_o,
    output logic             stat_o
);
    logic             src_tick;
    logic             adv;
    logic             wrap_hit;
    logic             evt;
    logic [CNT_W-1:0] count_q;
    logic             stat_q;

    // Tick source choice, interval compare and event detect.
    always_comb begin
        src_tick = clk_cfg.src_sel ? alt_tick : 1'b1;
        wrap_hit = ivl_mode && (count_q == interval);
        evt      = !rst_stb && !halt && adv && wrap_hit;
    end

    tmr_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (halt || rst_stb),
        .src_tick (src_tick),
        .pre_en   (clk_cfg.pre_en),
        .exp_sel  (clk_cfg.exp_sel),
        .adv_o    (adv)
    );

    // Counter: zeroed by the strobe, advances while running, wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              count_q <= '0;
        else if (rst_stb)        count_q <= '0;
        else if (!halt && adv)   count_q <= wrap_hit ? '0 : count_q + CNT_W'(1);
    end

    // Event flag: set by an event, cleared by a read, event wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (evt)      stat_q <= 1'b1;
        else if (stat_rd)  stat_q <= 1'b0;
    end

    assign count_o = count_q;
    assign stat_o  = stat_q;

    p_strobe_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb |=> (count_q == '0));
    p_hold_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !rst_stb) |=> $stable(count_q));
    p_alt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_cfg.src_sel && !alt_tick && !rst_stb) |=> $stable(count_q));
    p_free_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(ivl_mode));
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !adv) |=> !stat_q);
endmodule

// File: rtl/prescaled_interval_timer.sv
// Top of the timer: register decode, per-channel control registers,
// registered read mux and interrupt gating around NUM_CH channels.
// Assumes: bus_we and bus_re are never high together; byte addressing.
module prescaled_interval_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              alt_tick_i,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int CFG_W = $bits(clk_cfg_t);

    logic [NUM_CH-1:0] sel_clk, sel_cnt, sel_val, sel_ivl, sel_sta, sel_ier;
    logic [NUM_CH-1:0] halt_q, mode_q, ier_q, rst_stb, stat_rd, stat_w;
    clk_cfg_t          clk_q [NUM_CH];
    logic [CNT_W-1:0]  ivl_q [NUM_CH];
    logic [CNT_W-1:0]  cnt_w [NUM_CH];
    logic [DATA_W-1:0] rd_mux;
    logic              rd_hit;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Address decode for this channel's slot in every group.
        always_comb begin
            sel_clk[i] = (bus_addr == ADDR_W'(OFS_CLK + CH_STRIDE*i));
            sel_cnt[i] = (bus_addr == ADDR_W'(OFS_CNT + CH_STRIDE*i));
            sel_val[i] = (bus_addr == ADDR_W'(OFS_VAL + CH_STRIDE*i));
            sel_ivl[i] = (bus_addr == ADDR_W'(OFS_IVL + CH_STRIDE*i));
            sel_sta[i] = (bus_addr == ADDR_W'(OFS_STA + CH_STRIDE*i));
            sel_ier[i] = (bus_addr == ADDR_W'(OFS_IER + CH_STRIDE*i));
            rst_stb[i] = bus_we && sel_cnt[i] && bus_wdata[4];
            stat_rd[i] = bus_re && sel_sta[i];
        end

        // Writable control registers of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_q[i]  <= '0;
                halt_q[i] <= 1'b1;
                mode_q[i] <= 1'b0;
                ivl_q[i]  <= '1;
                ier_q[i]  <= 1'b0;
            end else if (bus_we) begin
                if (sel_clk[i]) clk_q[i] <= clk_cfg_t'(bus_wdata[CFG_W-1:0]);
                if (sel_cnt[i]) begin
                    halt_q[i] <= bus_wdata[0];
                    mode_q[i] <= bus_wdata[1];
                end
                if (sel_ivl[i]) ivl_q[i] <= bus_wdata[CNT_W-1:0];
                if (sel_ier[i]) ier_q[i] <= bus_wdata[0];
            end
        end

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clk_cfg  (clk_q[i]),
            .halt     (halt_q[i]),
            .ivl_mode (mode_q[i]),
            .interval (ivl_q[i]),
            .rst_stb  (rst_stb[i]),
            .alt_tick (alt_tick_i),
            .stat_rd  (stat_rd[i]),
            .count_o  (cnt_w[i]),
            .stat_o   (stat_w[i])
        );

        assign irq_o[i] = stat_w[i] && ier_q[i];
    end

    // Read multiplexer over all mapped registers; misses return zero.
    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_clk[i]) begin rd_mux = DATA_W'(clk_q[i]);              rd_hit = 1'b1; end
            if (sel_cnt[i]) begin rd_mux = DATA_W'({mode_q[i], halt_q[i]}); rd_hit = 1'b1; end
            if (sel_val[i]) begin rd_mux = DATA_W'(cnt_w[i]);              rd_hit = 1'b1; end
            if (sel_ivl[i]) begin rd_mux = DATA_W'(ivl_q[i]);              rd_hit = 1'b1; end
            if (sel_sta[i]) begin rd_mux = DATA_W'(stat_w[i]);             rd_hit = 1'b1; end
            if (sel_ier[i]) begin rd_mux = DATA_W'(ier_q[i]);              rd_hit = 1'b1; end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       bus_rdata <= '0;
        else if (bus_re)  bus_rdata <= rd_mux;
    end

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !rd_hit) |=> (bus_rdata == '0));
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/prescaled_interval_timer_test.sv
module prescaled_interval_timer_test;
    localparam int A_CLK = 'h00, A_CNT = 'h0C, A_VAL = 'h18,
                   A_IVL = 'h24, A_STA = 'h54, A_IER = 'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        alt_tick_i = 1'b1;
    logic [2:0]  irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    prescaled_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .alt_tick_i(alt_tick_i), .irq_o(irq_o));

    always #2.5 clk = ~clk;

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write.
    task automatic wr(int addr, int data);
        bus_addr = 8'(addr); bus_wdata = 32'(data); bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Read issued at a falling edge; value sampled one edge later (R11).
    task automatic rd(int addr, output int val);
        bus_addr = 8'(addr); bus_re = 1'b1;
        @(posedge clk); @(negedge clk);
        val = int'(bus_rdata);
        bus_re = 1'b0;
    endtask

    function automatic int exp_count(int w, int d, int n, bit mode);
        int a = w / d;
        return mode ? a % (n + 1) : a % 65536;
    endfunction

    function automatic int exp_flag(int w, int d, int n, bit mode);
        return (mode && ((w + 1) / d) >= n + 1) ? 1 : 0;
    endfunction

    initial begin
        #(5.0 * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CNT, v);      check("R1 cnt ctrl", v, 1);
        rd(A_IVL, v);      check("R1 interval ch0", v, 'hFFFF);
        rd(A_IVL + 8, v);  check("R1 interval ch2", v, 'hFFFF);
        rd(A_CLK + 4, v);  check("R1 clk ctrl", v, 0);
        rd(A_VAL, v);      check("R1 count", v, 0);
        rd(A_IER + 8, v);  check("R1 ier", v, 0);
        check("R1 irq", irq_o, 0);

        // R10 map, stride, unmapped, read-only writes
        wr(A_CLK + 8, 'h15);
        rd(A_CLK + 8, v);  check("R10 stride ch2 clk", v, 'h15);
        rd(A_CLK + 4, v);  check("R10 ch1 untouched", v, 0);
        wr(A_CLK + 8, 0);
        rd('h30, v);       check("R10 unmapped", v, 0);
        rd('h01, v);       check("R10 misaligned", v, 0);
        wr(A_VAL, 'h1234);
        rd(A_VAL, v);      check("R10 count read-only", v, 0);
        wr(A_STA, 1);
        rd(A_STA, v);      check("R10 status read-only", v, 0);

        // R6 strobe not stored, upper bits ignored
        wr(A_CNT + 4, 'h23);
        rd(A_CNT + 4, v);  check("R6 0x23 readback", v, 3);
        wr(A_CNT + 4, 'h13);
        rd(A_CNT + 4, v);  check("R6 strobe reads 0", v, 3);

        // R5 halt and resume from held value
        wr(A_CNT, 'h10);
        repeat (10) @(negedge clk);
        wr(A_CNT, 'h01);
        rd(A_VAL, v);      check("R5 held", v, 11);
        repeat (20) @(negedge clk);
        rd(A_VAL, v);      check("R5 still held", v, 11);
        wr(A_CNT, 'h00);
        repeat (4) @(negedge clk);
        rd(A_VAL, v);      check("R5 resumed", v, 15);
        wr(A_CNT, 'h11);
        repeat (5) @(negedge clk);
        rd(A_VAL, v);      check("R6 strobe while halted", v, 0);

        // R4 alternate tick source
        wr(A_CLK + 8, 'h20);
        alt_tick_i = 1'b0;
        wr(A_CNT + 8, 'h10);
        repeat (10) @(negedge clk);
        rd(A_VAL + 8, v);  check("R4 alt idle", v, 0);
        alt_tick_i = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_VAL + 8, v);  check("R4 alt ticking", v, 5);
        wr(A_CNT + 8, 'h01);

        // R8 / R9 read clear, tie with event, irq gating and hold
        wr(A_CNT + 4, 'h01);
        wr(A_CLK + 4, 0);
        wr(A_IVL + 4, 4);
        wr(A_IER + 4, 0);
        rd(A_STA + 4, v);
        wr(A_CNT + 4, 'h12);
        repeat (9) @(negedge clk);
        check("R9 gated off", irq_o[1], 0);
        rd(A_STA + 4, v);  check("R7 flag after wrap", v, 1);
        rd(A_STA + 4, v);  check("R8 tie keeps flag", v, 1);
        rd(A_STA + 4, v);  check("R8 cleared", v, 0);
        wr(A_IER + 4, 1);
        repeat (3) @(negedge clk);
        check("R9 irq set", irq_o[1], 1);
        wr(A_CNT + 4, 'h03);
        repeat (10) @(negedge clk);
        check("R9 irq held", irq_o[1], 1);
        rd(A_STA + 4, v);  check("R8 flag read", v, 1);
        check("R9 irq cleared", irq_o[1], 0);

        // R2 free wrap past 0xFFFF without flag
        wr(A_CNT + 4, 'h01);
        wr(A_CLK + 4, 0);
        wr(A_CNT + 4, 'h10);
        repeat (65537) @(negedge clk);
        rd(A_VAL + 4, v);  check("R2 wrap", v, 1);
        check("R2 no irq", irq_o[1], 0);
        rd(A_STA + 4, v);  check("R2 no flag", v, 0);
        wr(A_CNT + 4, 'h01);

        // R3 / R7 random trials
        for (int t = 0; t < 40; t++) begin
            int ch = int'($urandom % 3);
            int p = int'($urandom % 4);
            bit pre = 1'($urandom % 2);
            bit mode = 1'($urandom % 2);
            int n = int'($urandom % 20);
            int w = int'($urandom % 150);
            int d = pre ? (1 << (p + 1)) : 1;
            wr(A_CNT + 4*ch, 'h01);
            wr(A_CLK + 4*ch, (p << 1) | pre);
            wr(A_IVL + 4*ch, n);
            wr(A_IER + 4*ch, 1);
            rd(A_STA + 4*ch, v);
            wr(A_CNT + 4*ch, 'h10 | (mode << 1));
            repeat (w) @(negedge clk);
            rd(A_VAL + 4*ch, v);
            check(mode ? "R7 interval count" : "R3 prescaled count", v, exp_count(w, d, n, mode));
            check("R9 irq random", irq_o[ch], exp_flag(w, d, n, mode));
            rd(A_STA + 4*ch, v);
            check("R7 flag random", v, exp_flag(w, d, n, mode));
            wr(A_CNT + 4*ch, 'h01);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule